// File: doc/BRIEF.md
# Path Overhead Capture and Inhibit

This block takes a receive byte stream in which every byte carries a 4-bit position code naming which of the nine path-overhead bytes it is. Each overhead byte is registered and presented one cycle later on a parallel overhead output with a valid strobe and its index. The same byte is also stored in a bank of nine registers that a processor reads through a combinational read port.

The block also derives the inhibit that governs overhead processing. An active-low global disable stops all capture and clears the captured state. A second, narrower inhibit gates the signal-label (C2) and trace (J1) processing registers. That inhibit is built from a clock-loss alarm and from alarms whose relevance depends on two mode pins. The first pin enables pointer tracking. The second selects whether upstream AIS comes from the overhead-byte detector or from two status leads. While the narrow inhibit is active, the C2/J1 working registers are held at zero. They pick up again only from the first frame start (J1 byte) after every inhibit condition has cleared.

Top module: `poh_overhead_top`

## Requirements
- R1: Position codes map as 0=J1, 1=B3, 2=C2, 3=G1, 4=F2, 5=H4, 6=Z3, 7=Z4, 8=Z5. A valid byte with code 9 to 15 produces no output strobe and writes no register.
- R2: A valid byte with code 0 to 8, accepted while not globally disabled, appears on `oh_byte` with `oh_vld` high and `oh_idx` equal to its code exactly one cycle later. Otherwise `oh_vld` is low.
- R3: `rd_data` returns the last byte captured for position code `rd_addr`. Addresses 9 to 15 read zero.
- R4: While `glob_en_n` is low, `inh_all` and `inh_c2j1` are high, `oh_vld` is low from the next cycle, and every capture register reads zero from the next cycle.
- R5: A drop-clock loss alarm raises `inh_c2j1` in every mode.
- R6: A missing-J1-pulse alarm raises `inh_c2j1` only when `ptr_trk_en` is 0.
- R7: Loss-of-pointer and path-AIS alarms raise `inh_c2j1` only when `ptr_trk_en` is 1.
- R8: The overhead-byte AIS alarm raises `inh_c2j1` only when `ais_src_sel` is 0. Either status-lead alarm raises it only when `ais_src_sel` is 1.
- R9: In the cycle after `inh_c2j1` is high, `c2_work` and `j1_work` are zero.
- R10: After the inhibit clears, `j1_work` loads from the next J1 byte and `c2_work` from C2 bytes that follow it. A C2 byte arriving before that J1 leaves `c2_work` at zero.
- R11: After reset, `oh_vld`, `c2_work`, `j1_work` and all capture registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Stream byte |
| in_vld | input | 1 | Stream byte valid |
| in_pos | input | 4 | Overhead position code of the byte |
| glob_en_n | input | 1 | Active-low global overhead disable (low = disabled) |
| ptr_trk_en | input | 1 | Pointer-tracking enable mode pin |
| ais_src_sel | input | 1 | 0: overhead-byte AIS, 1: status leads |
| alm_clk_loss | input | 1 | Drop-bus clock loss alarm |
| alm_j1_loss | input | 1 | Missing J1 pulse alarm |
| alm_lop | input | 1 | Loss of pointer alarm |
| alm_path_ais | input | 1 | Receive path AIS alarm |
| alm_oh_ais | input | 1 | Overhead-byte AIS alarm |
| alm_lead_stat | input | 1 | Status lead alarm |
| alm_lead_ais | input | 1 | AIS lead alarm |
| rd_addr | input | 4 | Register read address (position code) |
| rd_data | output | 8 | Register read data |
| oh_vld | output | 1 | Overhead output strobe |
| oh_idx | output | 4 | Overhead output index |
| oh_byte | output | 8 | Overhead output byte |
| inh_all | output | 1 | Global processing inhibit |
| inh_c2j1 | output | 1 | C2/J1 processing inhibit |
| c2_work | output | 8 | C2 processing register |
| j1_work | output | 8 | J1 processing register |

## Verification
The bench sets each alarm alone in all four mode combinations. A design that decoded a mode pin backwards would inhibit C2/J1 on an alarm that should be ignored, or miss one that should act. It lifts an inhibit in mid-frame and then sends C2 before the next J1. A design that resumed at once would load a stale label instead of holding zero. It sends out-of-range codes 9 and 15 and checks that no strobe or register write follows. It also drops the global disable after filling the registers. A design that only gated capture without clearing would go on reading old bytes.

// File: rtl/poh_pkg.sv
// Package: shared widths and position codes for the path-overhead block.
// Assumes codes 0..NUM_POH-1 name overhead bytes; higher codes are unused.
package poh_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 4;
    localparam int NUM_POH = 9;

    typedef enum logic [IDX_W-1:0] {
        POS_J1 = 4'd0, POS_B3 = 4'd1, POS_C2 = 4'd2,
        POS_G1 = 4'd3, POS_F2 = 4'd4, POS_H4 = 4'd5,
        POS_Z3 = 4'd6, POS_Z4 = 4'd7, POS_Z5 = 4'd8
    } poh_pos_e;

    typedef struct packed {
        logic clk_loss;
        logic j1_loss;
        logic lop;
        logic path_ais;
        logic oh_ais;
        logic lead_stat;
        logic lead_ais;
    } poh_alarms_t;
endpackage

// File: rtl/poh_inhibit.sv
// Module: combines the global disable and the mode-qualified alarm set
// into the global inhibit and the C2/J1 inhibit. Purely combinational;
// assumes alarms are already synchronous to clk.
module poh_inhibit
    import poh_pkg::*;
(
    input  logic        glob_en_n,
    input  logic        ptr_trk_en,
    input  logic        ais_src_sel,
    input  poh_alarms_t alm,
    output logic        inh_all,
    output logic        inh_c2j1
);
    logic ptr_term;
    logic ais_term;

    // Mode-dependent alarm selection and the final OR.
    always_comb begin
        inh_all  = ~glob_en_n;
        ptr_term = ptr_trk_en ? (alm.lop | alm.path_ais) : alm.j1_loss;
        ais_term = ais_src_sel ? (alm.lead_stat | alm.lead_ais) : alm.oh_ais;
        inh_c2j1 = inh_all | alm.clk_loss | ptr_term | ais_term;
    end
endmodule

// File: rtl/poh_capture_bank.sv
// Module: nine processor-readable capture registers plus the registered
// external overhead output. Assumes in_pos outside 0..N-1 marks no byte.
// Global inhibit clears the bank and suppresses the output strobe.
module poh_capture_bank
    import poh_pkg::*;
#(
    parameter int N  = NUM_POH,
    parameter int BW = BYTE_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inh_all,
    input  logic [BW-1:0] in_byte,
    input  logic          in_vld,
    input  logic [IW-1:0] in_pos,
    input  logic [IW-1:0] rd_addr,
    output logic [BW-1:0] rd_data,
    output logic          oh_vld,
    output logic [IW-1:0] oh_idx,
    output logic [BW-1:0] oh_byte
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic          accept;
    logic [BW-1:0] cap_q [N];

    // Qualify a byte for capture.
    always_comb accept = in_vld && (in_pos <= LAST) && !inh_all;

    for (genvar g = 0; g < N; g++) begin : g_cap
        // Per-position capture register, cleared by reset or global inhibit.
        always_ff @(posedge clk) begin
            if (!rst_n || inh_all)
                cap_q[g] <= '0;
            else if (accept && in_pos == IW'(g))
                cap_q[g] <= in_byte;
        end
    end

    // Register the external overhead output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oh_vld  <= 1'b0;
            oh_idx  <= '0;
            oh_byte <= '0;
        end else begin
            oh_vld <= accept;
            if (accept) begin
                oh_idx  <= in_pos;
                oh_byte <= in_byte;
            end
        end
    end

    // Combinational processor read mux.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++)
            if (rd_addr == IW'(k)) rd_data = cap_q[k];
    end
endmodule

// File: rtl/poh_c2j1_proc.sv
// Module: C2/J1 processing registers. Held at zero while inhibited;
// re-armed only by the first J1 byte after the inhibit clears.
module poh_c2j1_proc
    import poh_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inh_c2j1,
    input  logic [BW-1:0] in_byte,
    input  logic          in_vld,
    input  logic [IW-1:0] in_pos,
    output logic [BW-1:0] c2_work,
    output logic [BW-1:0] j1_work
);
    logic armed_q;

    // Arm on frame start, hold reset values while inhibited.
    always_ff @(posedge clk) begin
        if (!rst_n || inh_c2j1) begin
            armed_q <= 1'b0;
            c2_work <= '0;
            j1_work <= '0;
        end else if (in_vld && in_pos == POS_J1) begin
            armed_q <= 1'b1;
            j1_work <= in_byte;
        end else if (in_vld && in_pos == POS_C2 && armed_q) begin
            c2_work <= in_byte;
        end
    end
endmodule

// File: rtl/poh_overhead_top.sv
// Top: path-overhead capture with mode-dependent processing inhibit.
// Assumes one byte per cycle at most and synchronous alarm inputs.
module poh_overhead_top
    import poh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_byte,
    input  logic       in_vld,
    input  logic [3:0] in_pos,
    input  logic       glob_en_n,
    input  logic       ptr_trk_en,
    input  logic       ais_src_sel,
    input  logic       alm_clk_loss,
    input  logic       alm_j1_loss,
    input  logic       alm_lop,
    input  logic       alm_path_ais,
    input  logic       alm_oh_ais,
    input  logic       alm_lead_stat,
    input  logic       alm_lead_ais,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       oh_vld,
    output logic [3:0] oh_idx,
    output logic [7:0] oh_byte,
    output logic       inh_all,
    output logic       inh_c2j1,
    output logic [7:0] c2_work,
    output logic [7:0] j1_work
);
    poh_alarms_t alm;

    // Bundle the alarm pins.
    always_comb alm = '{clk_loss: alm_clk_loss, j1_loss: alm_j1_loss,
                        lop: alm_lop, path_ais: alm_path_ais,
                        oh_ais: alm_oh_ais, lead_stat: alm_lead_stat,
                        lead_ais: alm_lead_ais};

    poh_inhibit u_inh (
        .glob_en_n(glob_en_n), .ptr_trk_en(ptr_trk_en),
        .ais_src_sel(ais_src_sel), .alm(alm),
        .inh_all(inh_all), .inh_c2j1(inh_c2j1)
    );

    poh_capture_bank u_bank (
        .clk(clk), .rst_n(rst_n), .inh_all(inh_all),
        .in_byte(in_byte), .in_vld(in_vld), .in_pos(in_pos),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .oh_vld(oh_vld), .oh_idx(oh_idx), .oh_byte(oh_byte)
    );

    poh_c2j1_proc u_proc (
        .clk(clk), .rst_n(rst_n), .inh_c2j1(inh_c2j1),
        .in_byte(in_byte), .in_vld(in_vld), .in_pos(in_pos),
        .c2_work(c2_work), .j1_work(j1_work)
    );
endmodule

// File: rtl/poh_overhead_checker.sv
// Checker: temporal properties of the overhead block, bound to the top.
module poh_overhead_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] in_byte,
    input logic       in_vld,
    input logic [3:0] in_pos,
    input logic       glob_en_n,
    input logic       ptr_trk_en,
    input logic       alm_j1_loss,
    input logic       alm_clk_loss,
    input logic       oh_vld,
    input logic [3:0] oh_idx,
    input logic [7:0] oh_byte,
    input logic       inh_c2j1,
    input logic [7:0] c2_work,
    input logic [7:0] j1_work
);
    assert_ext_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_pos <= 4'd8 && glob_en_n) |=>
            (oh_vld && oh_idx == $past(in_pos) && oh_byte == $past(in_byte)));

    assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_pos > 4'd8) |=> !oh_vld);

    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        oh_vld |-> oh_idx <= 4'd8);

    assert_glob_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_n |=> !oh_vld);

    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inh_c2j1 |=> (c2_work == 8'd0 && j1_work == 8'd0));

    assert_clk_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alm_clk_loss |-> inh_c2j1);

    assert_j1_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_j1_loss && !ptr_trk_en) |-> inh_c2j1);
endmodule

bind poh_overhead_top poh_overhead_checker i_chk (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
    .in_pos(in_pos), .glob_en_n(glob_en_n), .ptr_trk_en(ptr_trk_en),
    .alm_j1_loss(alm_j1_loss), .alm_clk_loss(alm_clk_loss),
    .oh_vld(oh_vld), .oh_idx(oh_idx), .oh_byte(oh_byte),
    .inh_c2j1(inh_c2j1), .c2_work(c2_work), .j1_work(j1_work)
);

// File: tb/test_poh_overhead_top.sv
// Directed bench for poh_overhead_top; one task per scenario.
module test_poh_overhead_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_vld = 1'b0;
    logic [3:0] in_pos = '0;
    logic       glob_en_n = 1'b1;
    logic       ptr_trk_en = 1'b0;
    logic       ais_src_sel = 1'b0;
    logic       alm_clk_loss = 1'b0, alm_j1_loss = 1'b0, alm_lop = 1'b0;
    logic       alm_path_ais = 1'b0, alm_oh_ais = 1'b0;
    logic       alm_lead_stat = 1'b0, alm_lead_ais = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data, oh_byte, c2_work, j1_work;
    logic       oh_vld, inh_all, inh_c2j1;
    logic [3:0] oh_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    poh_overhead_top i_poh_overhead_top (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_alarms();
        {alm_clk_loss, alm_j1_loss, alm_lop, alm_path_ais,
         alm_oh_ais, alm_lead_stat, alm_lead_ais} = '0;
    endtask

    // Drive one byte for one cycle; outputs are valid at the following negedge.
    task automatic send(input logic [3:0] pos, input logic [7:0] b);
        @(negedge clk);
        in_vld = 1'b1; in_pos = pos; in_byte = b;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 oh_vld", oh_vld, 0);
        check("R11 c2_work", c2_work, 0);
        check("R11 j1_work", j1_work, 0);
        for (int a = 0; a < 9; a++) begin
            rd_addr = 4'(a); #1;
            check("R11 rd_data", rd_data, 0);
        end
    endtask

    task automatic t_capture();
        for (int p = 0; p < 9; p++) begin
            send(4'(p), 8'(8'h30 + p));
            check("R2 oh_vld", oh_vld, 1);
            check("R2 oh_idx", oh_idx, p);
            check("R2 oh_byte", oh_byte, 8'h30 + p);
        end
        @(negedge clk);
        check("R2 idle strobe", oh_vld, 0);
        for (int a = 0; a < 9; a++) begin
            rd_addr = 4'(a); #1;
            check("R3 readback", rd_data, 8'h30 + a);
        end
        rd_addr = 4'd12; #1;
        check("R3 unused address", rd_data, 0);
        check("R1 J1 tracked into j1_work", j1_work, 8'h30);
        check("R10 C2 after J1", c2_work, 8'h32);
    endtask

    task automatic t_bad_code();
        send(4'd9, 8'hAA);
        check("R1 code 9 strobe", oh_vld, 0);
        send(4'd15, 8'hBB);
        check("R1 code 15 strobe", oh_vld, 0);
        for (int a = 0; a < 9; a++) begin
            rd_addr = 4'(a); #1;
            check("R1 no write", rd_data, 8'h30 + a);
        end
    endtask

    task automatic t_global();
        @(negedge clk);
        glob_en_n = 1'b0; #1;
        check("R4 inh_all", inh_all, 1);
        check("R4 inh_c2j1", inh_c2j1, 1);
        send(4'd3, 8'h77);
        check("R4 no strobe", oh_vld, 0);
        for (int a = 0; a < 9; a++) begin
            rd_addr = 4'(a); #1;
            check("R4 cleared", rd_data, 0);
        end
        check("R9 c2 zero on global", c2_work, 0);
        check("R9 j1 zero on global", j1_work, 0);
        glob_en_n = 1'b1;
        send(4'd3, 8'h78);
        check("R4 capture resumes", oh_byte, 8'h78);
    endtask

    // Probe each alarm alone in all four mode combinations.
    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            ptr_trk_en = m[0]; ais_src_sel = m[1];
            clear_alarms(); #1;
            check("R5 idle no inhibit", inh_c2j1, 0);
            alm_clk_loss = 1'b1; #1;
            check("R5 clock loss", inh_c2j1, 1);
            clear_alarms(); alm_j1_loss = 1'b1; #1;
            check("R6 j1 loss", inh_c2j1, m[0] ? 0 : 1);
            clear_alarms(); alm_lop = 1'b1; #1;
            check("R7 lop", inh_c2j1, m[0] ? 1 : 0);
            clear_alarms(); alm_path_ais = 1'b1; #1;
            check("R7 path ais", inh_c2j1, m[0] ? 1 : 0);
            clear_alarms(); alm_oh_ais = 1'b1; #1;
            check("R8 oh ais", inh_c2j1, m[1] ? 0 : 1);
            clear_alarms(); alm_lead_stat = 1'b1; #1;
            check("R8 status lead", inh_c2j1, m[1] ? 1 : 0);
            clear_alarms(); alm_lead_ais = 1'b1; #1;
            check("R8 ais lead", inh_c2j1, m[1] ? 1 : 0);
            check("R4 inh_all stays low", inh_all, 0);
            clear_alarms();
        end
        ptr_trk_en = 1'b0; ais_src_sel = 1'b0; #1;
    endtask

    task automatic t_resume();
        send(4'd0, 8'h51);
        send(4'd2, 8'h52);
        check("R10 armed c2", c2_work, 8'h52);
        @(negedge clk);
        alm_clk_loss = 1'b1;
        @(negedge clk);
        check("R9 c2 held zero", c2_work, 0);
        check("R9 j1 held zero", j1_work, 0);
        send(4'd0, 8'h61);
        check("R9 j1 ignored while inhibited", j1_work, 0);
        alm_clk_loss = 1'b0;
        send(4'd2, 8'h62);
        check("R10 stale C2 ignored", c2_work, 0);
        check("R10 j1 waits", j1_work, 0);
        send(4'd0, 8'h71);
        check("R10 j1 reloads", j1_work, 8'h71);
        send(4'd2, 8'h72);
        check("R10 c2 reloads", c2_work, 8'h72);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_bad_code();
        t_global();
        t_modes();
        t_resume();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule